// File: doc/BRIEF.md
# Packed-Lane Integer Min/Max Unit

This unit picks the smaller or the larger of two integer operands and then combines the pick with a third word. Operand A and operand B may each be a full 32-bit word, a halfword or a byte taken from a packed register, and each may be signed or unsigned. B can also come from a 20-bit immediate in place of a register. Since the two operands may differ in signedness, the unit compares them on a 33-bit scale so the pick is always the true arithmetic minimum or maximum.

After the pick, an optional saturation step clamps the value to the range of the destination type. A post-stage then does one of three things with the third operand C: it writes a byte or halfword of the pick into C, it adds C, or it takes the minimum or maximum with C. A code can also leave the pick unchanged. The datapath is combinational up to a single output register. A valid strobe goes in with the operands, and a matching strobe comes out one clock later.

Top module: `vmx_minmax_unit`

## Requirements
- R1: Each operand's 2-bit width code selects halfword when 2, full word when 3, and byte for 0 or 1. A byte operand is the byte starting at bit select×8 of the source. It is sign-extended when the operand's signed flag is 1 and zero-extended otherwise.
- R2: A halfword operand uses only select bit 0 and takes bits starting at select[0]×16, extended per its signed flag. A full-word operand ignores the select and uses the whole source.
- R3: When `b_from_reg` is 0, B is the 20-bit immediate and `src_b` has no effect. The immediate is sign-extended from bit 19 if `b_signed` is 1 and zero-extended otherwise.
- R4: `op_max`=1 picks the larger operand and 0 picks the smaller. When both operands share signedness, the comparison uses that signedness.
- R5: When A and B differ in signedness, the pick is the true mathematical minimum or maximum. A maximum is then treated as unsigned and a minimum as signed.
- R6: With `sat_en`=1 and `dst_signed`=1, an unsigned pick above 0x7FFFFFFF becomes 0x7FFFFFFF.
- R7: With `sat_en`=1 and `dst_signed`=0, a signed pick that is negative becomes 0. Positive values are kept.
- R8: `post_op` values 0, 1, 2 and 3 return C with part of the saturated value written in. Code 0 writes the value's bits 15:0 into C[31:16]. Code 1 writes bits 15:0 into C[15:0]. Code 2 writes bits 7:0 into C[7:0]. Code 3 writes bits 7:0 into C[23:16].
- R9: `post_op`=4 returns the saturated value plus C, wrapping modulo 2^32.
- R10: `post_op`=5 returns the minimum of the saturated value and C, and `post_op`=6 returns the maximum. Both compare as signed when `dst_signed`=1 and as unsigned otherwise.
- R11: `post_op`=7 returns the saturated value unchanged, and C has no effect.
- R12: `out_valid` is asserted in the cycle after an `in_valid` cycle and is cleared by synchronous reset, which also zeroes `result`. `result` updates only after an `in_valid` cycle and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_a | input | 32 | Packed source for operand A |
| src_b | input | 32 | Packed source for operand B (register form) |
| src_c | input | 32 | Third operand for the post-stage |
| imm | input | 20 | Immediate used as B when `b_from_reg` is 0 |
| a_width | input | 2 | Width code of A |
| a_signed | input | 1 | A is signed |
| a_sel | input | 2 | Lane select of A |
| b_width | input | 2 | Width code of B (register form) |
| b_signed | input | 1 | B is signed |
| b_sel | input | 2 | Lane select of B (register form) |
| b_from_reg | input | 1 | 1: B from `src_b`, 0: B from `imm` |
| op_max | input | 1 | 1: maximum, 0: minimum |
| sat_en | input | 1 | Enable saturation to the destination type |
| dst_signed | input | 1 | Destination is signed |
| post_op | input | 3 | Post-stage code |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 32 | Registered result |

## Verification
Saturation and the post-stage act on the same value in one cycle, so a fault in their ordering shows up only when both are active together. The bench issues an unsigned pick above 0x7FFFFFFF with a signed destination and saturation on, together with accumulate or a min/max against C. It then checks that the post-stage result is built on the clamped 0x7FFFFFFF and not on the raw pick. It also issues operations back to back, so each registered result is compared in the same cycle in which the next operation is presented.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

    parameter int unsigned DW    = 32;
    parameter int unsigned IMM_W = 20;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 16;
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_H16 = 2'd1,
        LANE_W32 = 2'd2
    } lane_w_e;

    typedef enum logic [2:0] {
        POST_INS_HI16 = 3'd0,
        POST_INS_LO16 = 3'd1,
        POST_INS_B0   = 3'd2,
        POST_INS_B2   = 3'd3,
        POST_ACC      = 3'd4,
        POST_MIN      = 3'd5,
        POST_MAX      = 3'd6,
        POST_PASS     = 3'd7
    } post_e;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          sgn;
    } opnd_t;

    function automatic lane_w_e decode_width(input logic [1:0] code);
        case (code)
            2'd2:    return LANE_H16;
            2'd3:    return LANE_W32;
            default: return LANE_B8;
        endcase
    endfunction

    function automatic logic [DW:0] widen(input logic [DW-1:0] v, input logic s);
        return {s & v[DW-1], v};
    endfunction

endpackage

// File: rtl/vmx_lane_extract.sv
module vmx_lane_extract
    import vmx_pkg::*;
(
    input  logic [DW-1:0] raw,
    input  logic [1:0]    width_code,
    input  logic [1:0]    sel,
    input  logic          sgn,
    output opnd_t         opnd
);
    lane_w_e       w;
    logic [DW-1:0] byte_sh;
    logic [DW-1:0] half_sh;

    always_comb begin
        w       = decode_width(width_code);
        byte_sh = raw >> {sel, 3'b000};
        half_sh = raw >> {sel[0], 4'b0000};
        opnd.sgn = sgn;
        case (w)
            LANE_B8:  opnd.val = {{(DW-BYTE_W){sgn & byte_sh[BYTE_W-1]}}, byte_sh[BYTE_W-1:0]};
            LANE_H16: opnd.val = {{(DW-HALF_W){sgn & half_sh[HALF_W-1]}}, half_sh[HALF_W-1:0]};
            default:  opnd.val = raw;
        endcase
    end
endmodule

// File: rtl/vmx_operand_b.sv
module vmx_operand_b
    import vmx_pkg::*;
(
    input  logic [DW-1:0]    src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       b_width,
    input  logic [1:0]       b_sel,
    input  logic             b_signed,
    input  logic             b_from_reg,
    output opnd_t            opnd
);
    opnd_t reg_opnd;

    vmx_lane_extract u_bx (
        .raw        (src_b),
        .width_code (b_width),
        .sel        (b_sel),
        .sgn        (b_signed),
        .opnd       (reg_opnd)
    );

    always_comb begin
        if (b_from_reg) begin
            opnd = reg_opnd;
        end else begin
            opnd.sgn = b_signed;
            opnd.val = {{(DW-IMM_W){b_signed & imm[IMM_W-1]}}, imm};
        end
    end
endmodule

// File: rtl/vmx_minmax_core.sv
module vmx_minmax_core
    import vmx_pkg::*;
(
    input  opnd_t         a,
    input  opnd_t         b,
    input  logic          op_max,
    output logic [DW-1:0] pick,
    output logic          pick_sgn
);
    logic [DW:0] a_w;
    logic [DW:0] b_w;
    logic        a_lt_b;

    always_comb begin
        a_w    = widen(a.val, a.sgn);
        b_w    = widen(b.val, b.sgn);
        a_lt_b = $signed(a_w) < $signed(b_w);
        if (op_max) pick = a_lt_b ? b.val : a.val;
        else        pick = a_lt_b ? a.val : b.val;
        pick_sgn = (a.sgn == b.sgn) ? a.sgn : ~op_max;
    end
endmodule

// File: rtl/vmx_post_stage.sv
module vmx_post_stage
    import vmx_pkg::*;
(
    input  logic [DW-1:0] pick,
    input  logic          pick_sgn,
    input  logic          sat_en,
    input  logic          dst_signed,
    input  logic [2:0]    post_op,
    input  logic [DW-1:0] src_c,
    output logic [DW-1:0] sat_val,
    output logic [DW-1:0] out_val
);
    logic c_lt;

    always_comb begin
        sat_val = pick;
        if (sat_en && dst_signed && !pick_sgn && pick[DW-1])
            sat_val = SMAX;
        else if (sat_en && !dst_signed && pick_sgn && pick[DW-1])
            sat_val = '0;

        c_lt = dst_signed ? ($signed(sat_val) < $signed(src_c)) : (sat_val < src_c);

        case (post_e'(post_op))
            POST_INS_HI16: out_val = {sat_val[HALF_W-1:0], src_c[HALF_W-1:0]};
            POST_INS_LO16: out_val = {src_c[DW-1:HALF_W], sat_val[HALF_W-1:0]};
            POST_INS_B0:   out_val = {src_c[DW-1:BYTE_W], sat_val[BYTE_W-1:0]};
            POST_INS_B2:   out_val = {src_c[DW-1:HALF_W+BYTE_W], sat_val[BYTE_W-1:0],
                                      src_c[HALF_W-1:0]};
            POST_ACC:      out_val = sat_val + src_c;
            POST_MIN:      out_val = c_lt ? sat_val : src_c;
            POST_MAX:      out_val = c_lt ? src_c : sat_val;
            default:       out_val = sat_val;
        endcase
    end
endmodule

// File: rtl/vmx_minmax_unit.sv
module vmx_minmax_unit
    import vmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       src_a,
    input  logic [31:0]       src_b,
    input  logic [31:0]       src_c,
    input  logic [19:0]       imm,
    input  logic [1:0]        a_width,
    input  logic              a_signed,
    input  logic [1:0]        a_sel,
    input  logic [1:0]        b_width,
    input  logic              b_signed,
    input  logic [1:0]        b_sel,
    input  logic              b_from_reg,
    input  logic              op_max,
    input  logic              sat_en,
    input  logic              dst_signed,
    input  logic [2:0]        post_op,
    output logic              out_valid,
    output logic [31:0]       result
);
    opnd_t         a_op;
    opnd_t         b_op;
    logic [DW-1:0] pick;
    logic          pick_sgn;
    logic [DW-1:0] sat_val;
    logic [DW-1:0] next_val;

    vmx_lane_extract u_ax (
        .raw        (src_a),
        .width_code (a_width),
        .sel        (a_sel),
        .sgn        (a_signed),
        .opnd       (a_op)
    );

    vmx_operand_b u_b (
        .src_b      (src_b),
        .imm        (imm),
        .b_width    (b_width),
        .b_sel      (b_sel),
        .b_signed   (b_signed),
        .b_from_reg (b_from_reg),
        .opnd       (b_op)
    );

    vmx_minmax_core u_mm (
        .a        (a_op),
        .b        (b_op),
        .op_max   (op_max),
        .pick     (pick),
        .pick_sgn (pick_sgn)
    );

    // R4/R5: the pick is one of the operands and bounds both on the 33-bit scale
    p_pick_is_operand_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (pick == a_op.val || pick == b_op.val));
    p_true_max_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_max) |->
            ($signed(widen(pick, pick_sgn)) >= $signed(widen(a_op.val, a_op.sgn)) &&
             $signed(widen(pick, pick_sgn)) >= $signed(widen(b_op.val, b_op.sgn))));
    p_true_min_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_max) |->
            ($signed(widen(pick, pick_sgn)) <= $signed(widen(a_op.val, a_op.sgn)) &&
             $signed(widen(pick, pick_sgn)) <= $signed(widen(b_op.val, b_op.sgn))));

    vmx_post_stage u_post (
        .pick       (pick),
        .pick_sgn   (pick_sgn),
        .sat_en     (sat_en),
        .dst_signed (dst_signed),
        .post_op    (post_op),
        .src_c      (src_c),
        .sat_val    (sat_val),
        .out_val    (next_val)
    );

    p_sat_signed_dst_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && dst_signed && !pick_sgn) |-> !sat_val[DW-1]);
    p_sat_unsigned_dst_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && !dst_signed && pick_sgn) |-> !sat_val[DW-1]);
    p_merge_keeps_c_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && post_op == 3'd0) |-> next_val[HALF_W-1:0] == src_c[HALF_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_val;
        end
    end

    p_valid_follows_r12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_no_valid_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
endmodule

// File: tb/tb_vmx_minmax_unit.sv
module tb_vmx_minmax_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] src_a, src_b, src_c;
    logic [19:0] imm;
    logic [1:0]  a_width, a_sel, b_width, b_sel;
    logic        a_signed, b_signed, b_from_reg, op_max, sat_en, dst_signed;
    logic [2:0]  post_op;
    logic        out_valid;
    logic [31:0] result;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    vmx_minmax_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm(imm),
        .a_width(a_width), .a_signed(a_signed), .a_sel(a_sel),
        .b_width(b_width), .b_signed(b_signed), .b_sel(b_sel),
        .b_from_reg(b_from_reg), .op_max(op_max), .sat_en(sat_en),
        .dst_signed(dst_signed), .post_op(post_op),
        .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        src_a = '0; src_b = '0; src_c = '0; imm = '0;
        a_width = 2'd3; a_signed = 0; a_sel = 0;
        b_width = 2'd3; b_signed = 0; b_sel = 0;
        b_from_reg = 1; op_max = 0; sat_en = 0; dst_signed = 0; post_op = 3'd7;
    endtask

    // issue one operation and check the registered result one clock later
    task automatic run(input string tag, input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check({tag, " out_valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, result, exp);
    endtask

    task automatic t_reset();
        rst = 1; in_valid = 0; defaults();
        repeat (3) @(negedge clk);
        check("R12 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R12 reset result", result, 32'd0);
        rst = 0;
    endtask

    task automatic t_byte_lanes();
        defaults();
        src_a = 32'h80FF7F01; a_width = 2'd0; a_sel = 2'd2;
        src_b = 32'hFFFFFFFF;
        run("R1 unsigned byte sel2", 32'h000000FF);
        a_signed = 1; b_signed = 1; src_b = 32'd5;
        run("R1 signed byte sel2", 32'hFFFFFFFF);
        a_sel = 2'd3; src_b = 32'd0;
        run("R1 signed byte sel3", 32'hFFFFFF80);
    endtask

    task automatic t_half_word();
        defaults();
        src_a = 32'h80FF7F01; src_b = 32'hFFFFFFFF;
        a_width = 2'd2; a_sel = 2'd3;
        run("R2 half uses sel bit0", 32'h000080FF);
        a_width = 2'd3; a_sel = 2'd2;
        run("R2 word ignores sel", 32'h80FF7F01);
        a_width = 2'd1; a_sel = 2'd1;
        run("R1 code1 is byte", 32'h0000007F);
    endtask

    task automatic t_immediate();
        defaults();
        b_from_reg = 0; src_b = 32'hDEADBEEF; imm = 20'h80001;
        a_signed = 1; b_signed = 1;
        run("R3 imm sign extended", 32'hFFF80001);
        a_signed = 0; b_signed = 0; op_max = 1;
        run("R3 imm zero extended, src_b ignored", 32'h00080001);
    endtask

    task automatic t_same_sign();
        defaults();
        src_a = 32'hFFFFFFF0; src_b = 32'd3; a_signed = 1; b_signed = 1;
        op_max = 1; run("R4 signed max", 32'd3);
        op_max = 0; run("R4 signed min", 32'hFFFFFFF0);
        a_signed = 0; b_signed = 0;
        op_max = 1; run("R4 unsigned max", 32'hFFFFFFF0);
        op_max = 0; run("R4 unsigned min", 32'd3);
    endtask

    task automatic t_mixed_sign();
        defaults();
        src_a = 32'hFFFFFFF0; a_signed = 1; src_b = 32'h80000000; b_signed = 0;
        op_max = 1; run("R5 mixed max", 32'h80000000);
        op_max = 0; run("R5 mixed min", 32'hFFFFFFF0);
        src_a = 32'hFFFFFFFF; a_signed = 0; src_b = 32'd1; b_signed = 1;
        op_max = 1; run("R5 mixed max unsigned big", 32'hFFFFFFFF);
        op_max = 0; run("R5 mixed min small", 32'd1);
    endtask

    task automatic t_saturate();
        defaults();
        src_a = 32'h90000000; src_b = 32'd5; op_max = 1;
        run("R6 no sat", 32'h90000000);
        sat_en = 1; dst_signed = 1;
        run("R6 clamp to smax", 32'h7FFFFFFF);
        src_a = 32'hFFFFFFF0; a_signed = 1; src_b = 32'h80000000;
        run("R6 mixed max clamp", 32'h7FFFFFFF);
        defaults();
        src_a = 32'hFFFFFFF0; src_b = 32'd3; a_signed = 1; b_signed = 1; sat_en = 1;
        run("R7 negative clamps to 0", 32'd0);
        op_max = 1;
        run("R7 positive kept", 32'd3);
    endtask

    task automatic t_merge();
        defaults();
        src_a = 32'h12345678; src_b = 32'hFFFFFFFF; src_c = 32'hAABBCCDD;
        post_op = 3'd0; run("R8 insert hi16", 32'h5678CCDD);
        post_op = 3'd1; run("R8 insert lo16", 32'hAABB5678);
        post_op = 3'd2; run("R8 insert byte0", 32'hAABBCC78);
        post_op = 3'd3; run("R8 insert byte2", 32'hAA78CCDD);
        post_op = 3'd7; run("R11 pass ignores C", 32'h12345678);
    endtask

    task automatic t_arith_post();
        defaults();
        src_a = 32'hFFFFFFF0; src_b = 32'd3; op_max = 1; src_c = 32'h20;
        post_op = 3'd4; run("R9 accumulate wraps", 32'h00000010);
        op_max = 0; src_c = 32'hFFFFFFFF;
        post_op = 3'd5; dst_signed = 1; run("R10 signed min with C", 32'hFFFFFFFF);
        dst_signed = 0; run("R10 unsigned min with C", 32'd3);
        post_op = 3'd6; dst_signed = 1; run("R10 signed max with C", 32'd3);
        dst_signed = 0; run("R10 unsigned max with C", 32'hFFFFFFFF);
    endtask

    // saturation and post-stage together: post-stage must see the clamped value
    task automatic t_sat_and_post();
        defaults();
        src_a = 32'h90000000; src_b = 32'd5; op_max = 1; sat_en = 1; dst_signed = 1;
        src_c = 32'd1; post_op = 3'd4;
        run("R6 R9 clamp then accumulate", 32'h80000000);
        src_c = 32'h80000001; post_op = 3'd6;
        run("R6 R10 clamp then signed max", 32'h7FFFFFFF);
    endtask

    task automatic t_timing();
        defaults();
        src_a = 32'd7; src_b = 32'd9;
        @(negedge clk);
        in_valid = 1;
        @(negedge clk);
        check("R12 b2b first", result, 32'd7);
        op_max = 1;
        @(negedge clk);
        in_valid = 0;
        check("R12 b2b second", result, 32'd9);
        src_a = 32'd100; src_b = 32'd200;
        @(negedge clk);
        check("R12 idle out_valid low", {31'd0, out_valid}, 32'd0);
        check("R12 idle result held", result, 32'd9);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_byte_lanes();
        t_half_word();
        t_immediate();
        t_same_sign();
        t_mixed_sign();
        t_saturate();
        t_merge();
        t_arith_post();
        t_sat_and_post();
        t_timing();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule